// File: doc/BRIEF.md
# Row/Column Parity Protected RAM

A small word-addressed storage array that guards its contents against bit upsets using two crossing sets of parity. Each stored word carries one even-parity bit of its own (the row check). A separate register holds one parity bit for every bit position, taken across all words (the column check). Together they cost one extra bit per word plus one word-wide register. This is far cheaper than per-word correcting codes.

A read whose row check passes is answered in the next cycle. A read whose row check fails starts a sweep over the whole array, one word per cycle, to recompute the column parities. Comparing them with the stored column register shows which bit positions disagree. If exactly one column disagrees, the bit at the crossing of the failing row and that column is flipped back. The repaired word is returned and also written back into the array. Any other pattern is reported as uncorrectable, and the stored word is left untouched.

Every write is a read-modify-write: the old word is folded out of the column register and the new word folded in. This holds the port busy for one extra cycle per write. A bit-flip input lets a test environment upset any stored bit, including a word's row parity bit, without touching the column register.

Top module: `xparity_ram`

## Requirements
- R1: After synchronous reset every word reads back as zero with no error flag, and `busy` is low.
- R2: A read accepted while `busy` is low and `wr_en` is low, on a word whose row parity holds, returns that word on `rd_data` with `rd_valid` high one cycle after acceptance. Both error flags are low.
- R3: A write accepted while `busy` is low raises `busy` for exactly the next cycle, then drops it. When `wr_en` and `rd_en` are both high in an accepting cycle, the write wins and the read is dropped.
- R4: Write, read and bit-flip requests presented while `busy` is high are ignored.
- R5: After any series of writes, a read of a word holding one flipped data bit returns the original data. `rd_valid` and `rd_corrected` are high together DEPTH+2 cycles after acceptance.
- R6: A corrected word is written back, so the next read of that word takes one cycle and carries no flag.
- R7: When the row check fails and two or more columns disagree, `rd_uncorrectable` is raised with the stored (faulty) data after DEPTH+2 cycles. The stored word is left unchanged, so a repeat read returns the same data and flag.
- R8: A flipped row parity bit (no column disagreeing) is reported as uncorrectable, with the stored data returned unchanged.
- R9: A bit-flip request (`inj_en` with `busy`, `wr_en` and `rd_en` low) inverts stored bit `inj_bit` of word `inj_addr`. Bit index DATA_W selects the word's row parity bit, and indices below it select data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | $clog2(DEPTH) | Write word address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(DEPTH) | Read word address |
| inj_en | input | 1 | Bit-flip request |
| inj_addr | input | $clog2(DEPTH) | Word to upset |
| inj_bit | input | $clog2(DATA_W+1) | Bit to upset (DATA_W = row parity) |
| busy | output | 1 | Port is occupied; requests are ignored |
| rd_valid | output | 1 | One-cycle pulse: read result present |
| rd_data | output | DATA_W | Read result |
| rd_corrected | output | 1 | Result was repaired from a single error |
| rd_uncorrectable | output | 1 | Error detected but not locatable |

## Verification
Clean reads follow random writes to random addresses, which separates a correct row check from false alarms. Single flips at random words and bits, made after long write runs, show whether the column register tracked every read-modify-write, since only then does exactly one column disagree. Flips in two words at different columns, three flips in one word, and a flipped row parity bit separate the many-column and zero-column cases from the correctable one. Requests held up during `busy`, and a write colliding with a read, show the arbitration.

// File: rtl/xparity_pkg.sv
package xparity_pkg;

    localparam int DEF_DEPTH  = 64;
    localparam int DEF_DATA_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_SWEEP = 2'd2,
        ST_FIX   = 2'd3
    } xp_state_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2,
        OP_FLIP = 2'd3
    } xp_op_t;

endpackage

// File: rtl/xparity_array.sv
module xparity_array #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 33,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wword,
    input  logic [AW-1:0]     raddr_a,
    output logic [WORD_W-1:0] rword_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [WORD_W-1:0] rword_b
);
    logic [WORD_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wword;
        end
    end

    assign rword_a = cells[raddr_a];
    assign rword_b = cells[raddr_b];
endmodule

// File: rtl/xparity_sweep.sv
module xparity_sweep #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [DATA_W-1:0] word_in,
    output logic [AW-1:0]     idx,
    output logic              last,
    output logic [DATA_W-1:0] acc
);
    assign last = (idx == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            idx <= '0;
            acc <= '0;
        end else if (step) begin
            acc <= acc ^ word_in;
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/xparity_syndrome.sv
module xparity_syndrome #(
    parameter int DATA_W = 32,
    localparam int CW    = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] stored_cols,
    input  logic [DATA_W-1:0] swept_cols,
    output logic [DATA_W-1:0] syndrome,
    output logic              single
);
    logic [CW-1:0] ones;

    assign syndrome = stored_cols ^ swept_cols;

    always_comb begin
        ones = '0;
        for (int i = 0; i < DATA_W; i++) ones = ones + CW'(syndrome[i]);
    end

    assign single = (ones == CW'(1));
endmodule

// File: rtl/xparity_ram.sv
module xparity_ram #(
    parameter int DEPTH  = xparity_pkg::DEF_DEPTH,
    parameter int DATA_W = xparity_pkg::DEF_DATA_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int WORD_W = DATA_W + 1,
    localparam int BW    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    input  logic              inj_en,
    input  logic [AW-1:0]     inj_addr,
    input  logic [BW-1:0]     inj_bit,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_corrected,
    output logic              rd_uncorrectable
);
    import xparity_pkg::*;

    xp_state_t         state;
    xp_op_t            op;
    logic [AW-1:0]     op_addr;
    logic [DATA_W-1:0] op_data;
    logic [DATA_W-1:0] col_par;

    logic              arr_we;
    logic [AW-1:0]     arr_waddr;
    logic [WORD_W-1:0] arr_wword;
    logic [AW-1:0]     port_a_addr;
    logic [WORD_W-1:0] port_a_word;
    logic [WORD_W-1:0] port_b_word;

    logic              sw_clear;
    logic              sw_step;
    logic [AW-1:0]     sw_idx;
    logic              sw_last;
    logic [DATA_W-1:0] sw_acc;

    logic [DATA_W-1:0] syn;
    logic              syn_single;

    logic [DATA_W-1:0] a_data;
    logic              a_par;
    logic              a_row_bad;

    assign busy = (state != ST_IDLE);

    // Request arbitration: write, then read, then bit flip
    always_comb begin
        op = OP_NONE;
        if (state == ST_IDLE) begin
            if (wr_en)       op = OP_WR;
            else if (rd_en)  op = OP_RD;
            else if (inj_en) op = OP_FLIP;
        end
    end

    always_comb begin
        if (state != ST_IDLE) port_a_addr = op_addr;
        else if (op == OP_RD) port_a_addr = rd_addr;
        else                  port_a_addr = inj_addr;
    end

    assign a_data    = port_a_word[DATA_W-1:0];
    assign a_par     = port_a_word[DATA_W];
    assign a_row_bad = (^a_data) != a_par;

    assign sw_clear = (op == OP_RD) && a_row_bad;
    assign sw_step  = (state == ST_SWEEP);

    // Array write port sharing
    always_comb begin
        arr_we    = 1'b0;
        arr_waddr = op_addr;
        arr_wword = port_a_word;
        unique case (state)
            ST_IDLE: begin
                if (op == OP_FLIP) begin
                    arr_we    = 1'b1;
                    arr_waddr = inj_addr;
                    arr_wword = port_a_word ^ (WORD_W'(1) << inj_bit);
                end
            end
            ST_WRITE: begin
                arr_we    = 1'b1;
                arr_wword = {^op_data, op_data};
            end
            ST_FIX: begin
                if (syn_single) begin
                    arr_we    = 1'b1;
                    arr_wword = {a_par, a_data ^ syn};
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state            <= ST_IDLE;
            op_addr          <= '0;
            op_data          <= '0;
            col_par          <= '0;
            rd_valid         <= 1'b0;
            rd_data          <= '0;
            rd_corrected     <= 1'b0;
            rd_uncorrectable <= 1'b0;
        end else begin
            rd_valid         <= 1'b0;
            rd_corrected     <= 1'b0;
            rd_uncorrectable <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (op == OP_WR) begin
                        op_addr <= wr_addr;
                        op_data <= wr_data;
                        state   <= ST_WRITE;
                    end else if (op == OP_RD) begin
                        op_addr <= rd_addr;
                        if (a_row_bad) begin
                            state <= ST_SWEEP;
                        end else begin
                            rd_data  <= a_data;
                            rd_valid <= 1'b1;
                        end
                    end
                end
                ST_WRITE: begin
                    col_par <= col_par ^ a_data ^ op_data;
                    state   <= ST_IDLE;
                end
                ST_SWEEP: begin
                    if (sw_last) state <= ST_FIX;
                end
                ST_FIX: begin
                    rd_valid <= 1'b1;
                    if (syn_single) begin
                        rd_data      <= a_data ^ syn;
                        rd_corrected <= 1'b1;
                    end else begin
                        rd_data          <= a_data;
                        rd_uncorrectable <= 1'b1;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    xparity_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .we      (arr_we),
        .waddr   (arr_waddr),
        .wword   (arr_wword),
        .raddr_a (port_a_addr),
        .rword_a (port_a_word),
        .raddr_b (sw_idx),
        .rword_b (port_b_word)
    );

    xparity_sweep #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_sweep (
        .clk     (clk),
        .rst     (rst),
        .clear   (sw_clear),
        .step    (sw_step),
        .word_in (port_b_word[DATA_W-1:0]),
        .idx     (sw_idx),
        .last    (sw_last),
        .acc     (sw_acc)
    );

    xparity_syndrome #(.DATA_W(DATA_W)) u_syn (
        .stored_cols (col_par),
        .swept_cols  (sw_acc),
        .syndrome    (syn),
        .single      (syn_single)
    );
endmodule

// File: rtl/xparity_ram_chk.sv
module xparity_ram_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic rd_en,
    input logic busy,
    input logic rd_valid,
    input logic rd_corrected,
    input logic rd_uncorrectable
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!busy && !rd_valid));

    // R3
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !busy) |=> busy ##1 !busy);

    // R2
    read_answer_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !busy) |=> (rd_valid || busy));

    // R5
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_corrected && rd_uncorrectable));

    // R7
    flag_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_corrected || rd_uncorrectable) |-> rd_valid);
endmodule

bind xparity_ram xparity_ram_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .wr_en            (wr_en),
    .rd_en            (rd_en),
    .busy             (busy),
    .rd_valid         (rd_valid),
    .rd_corrected     (rd_corrected),
    .rd_uncorrectable (rd_uncorrectable)
);

// File: tb/xparity_ram_test.sv
module xparity_ram_test;
    localparam int DEPTH  = 64;
    localparam int DATA_W = 32;
    localparam int AW     = $clog2(DEPTH);
    localparam int BW     = $clog2(DATA_W + 1);
    localparam int SLOW   = DEPTH + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [AW-1:0]     wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              inj_en = 1'b0;
    logic [AW-1:0]     inj_addr = '0;
    logic [BW-1:0]     inj_bit = '0;
    logic              busy;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic              rd_corrected;
    logic              rd_uncorrectable;

    int tests = 0;
    int fails = 0;
    logic [DATA_W-1:0] model [DEPTH];

    always #5 clk = ~clk;

    xparity_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_bit(inj_bit),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_corrected(rd_corrected), .rd_uncorrectable(rd_uncorrectable)
    );

    function automatic logic [DATA_W-1:0] bitmask(input int b);
        return DATA_W'(1) << b;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DATA_W-1:0] d,
                            input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        check(req, "busy after write", 64'(busy), 64'd1);
        @(negedge clk);
        check(req, "busy released", 64'(busy), 64'd0);
        model[a] = d;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DATA_W-1:0] d,
                           output logic cor, output logic unc, output int lat);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        lat = 0;
        d = '0; cor = 1'b0; unc = 1'b0;
        for (int k = 0; k < 4 * SLOW; k++) begin
            @(negedge clk);
            rd_en = 1'b0;
            lat++;
            if (rd_valid) begin
                d = rd_data; cor = rd_corrected; unc = rd_uncorrectable;
                break;
            end
        end
    endtask

    task automatic flip(input logic [AW-1:0] a, input int b);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_bit = BW'(b);
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic read_expect(input logic [AW-1:0] a, input logic [DATA_W-1:0] exp_d,
                               input logic exp_c, input logic exp_u, input int exp_lat,
                               input string req);
        logic [DATA_W-1:0] d;
        logic c, u;
        int lat;
        do_read(a, d, c, u, lat);
        check(req, "data", 64'(d), 64'(exp_d));
        check(req, "corrected flag", 64'(c), 64'(exp_c));
        check(req, "uncorrectable flag", 64'(u), 64'(exp_u));
        check(req, "latency", 64'(lat), 64'(exp_lat));
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic c, u;
        int lat;
        int a, a2, b, b2, b3;
        void'($urandom(32'h2bd7));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        check("R1", "busy after reset", 64'(busy), 64'd0);
        read_expect(AW'(0), '0, 1'b0, 1'b0, 1, "R1");
        read_expect(AW'(DEPTH - 1), '0, 1'b0, 1'b0, 1, "R1");

        // R2: clean reads after random writes
        for (int i = 0; i < 150; i++) begin
            a = $urandom_range(DEPTH - 1);
            do_write(AW'(a), $urandom, "R3");
        end
        for (int i = 0; i < DEPTH; i++) read_expect(AW'(i), model[i], 1'b0, 1'b0, 1, "R2");

        // R3: write wins over simultaneous read
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b1; wr_addr = AW'(5); rd_addr = AW'(9);
        wr_data = 32'hA5A5_0F0F;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R3", "read dropped on collision", 64'(rd_valid), 64'd0);
        check("R3", "busy on collision", 64'(busy), 64'd1);
        model[5] = 32'hA5A5_0F0F;
        // R4: requests during busy are ignored
        wr_en = 1'b1; wr_addr = AW'(7); wr_data = ~model[7];
        rd_en = 1'b1; rd_addr = AW'(7);
        inj_en = 1'b1; inj_addr = AW'(7); inj_bit = BW'(3);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; inj_en = 1'b0;
        check("R4", "no read answer while busy", 64'(rd_valid), 64'd0);
        check("R4", "no new busy from ignored write", 64'(busy), 64'd0);
        read_expect(AW'(7), model[7], 1'b0, 1'b0, 1, "R4");
        read_expect(AW'(5), model[5], 1'b0, 1'b0, 1, "R3");

        // R5, R6, R9: single data flips, interleaved with write runs
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 20; i++) begin
                a = $urandom_range(DEPTH - 1);
                do_write(AW'(a), $urandom, "R3");
            end
            a = $urandom_range(DEPTH - 1);
            b = $urandom_range(DATA_W - 1);
            flip(AW'(a), b);
            read_expect(AW'(a), model[a], 1'b1, 1'b0, SLOW, "R5");
            read_expect(AW'(a), model[a], 1'b0, 1'b0, 1, "R6");
        end
        // R5 boundary bits
        flip(AW'(0), 0);
        read_expect(AW'(0), model[0], 1'b1, 1'b0, SLOW, "R5");
        flip(AW'(DEPTH - 1), DATA_W - 1);
        read_expect(AW'(DEPTH - 1), model[DEPTH - 1], 1'b1, 1'b0, SLOW, "R5");

        // R7: two words upset in different columns
        a = 10; a2 = 40; b = 4; b2 = 21;
        flip(AW'(a), b);
        flip(AW'(a2), b2);
        read_expect(AW'(a), model[a] ^ bitmask(b), 1'b0, 1'b1, SLOW, "R7");
        read_expect(AW'(a), model[a] ^ bitmask(b), 1'b0, 1'b1, SLOW, "R7");
        flip(AW'(a), b);
        flip(AW'(a2), b2);
        read_expect(AW'(a), model[a], 1'b0, 1'b0, 1, "R7");

        // R7: three flips in one word
        a = 33; b = 1; b2 = 16; b3 = 30;
        flip(AW'(a), b); flip(AW'(a), b2); flip(AW'(a), b3);
        read_expect(AW'(a), model[a] ^ bitmask(b) ^ bitmask(b2) ^ bitmask(b3),
                    1'b0, 1'b1, SLOW, "R7");
        flip(AW'(a), b); flip(AW'(a), b2); flip(AW'(a), b3);
        read_expect(AW'(a), model[a], 1'b0, 1'b0, 1, "R7");

        // R8: row parity bit upset (bit index DATA_W)
        a = 22;
        flip(AW'(a), DATA_W);
        read_expect(AW'(a), model[a], 1'b0, 1'b1, SLOW, "R8");
        flip(AW'(a), DATA_W);
        read_expect(AW'(a), model[a], 1'b0, 1'b0, 1, "R9");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule